// File: doc/BRIEF.md
# Deadline Compare and Interrupt Engine

This block holds a set of 64-bit deadlines and raises interrupts when the free-running time base catches up with them. Each deadline has its own 32-bit period. A deadline counts as reached when its value is less than or equal to the current time, so a deadline that is already in the past still fires. When a reached deadline is marked periodic, its period is added to it and it stays armed. When it is marked one-shot, it raises its interrupt once and then disarms itself.

The engine holds three bit vectors, one bit per deadline: periodic mode, interrupt arm and interrupt pending. The interrupt line is the OR of the pending bits. The host reaches these vectors, the period registers and a read-only configuration word through a simple register port: a write strobe with an address and data, plus a combinational read port. Deadline values come from the neighbouring update logic through a load port. That same logic asserts a busy signal while it is working, and the engine does no comparison during those cycles.

Top module: `deadline_irq_engine`

## Requirements
- R1: After a synchronous active-low reset, the pending, arm and periodic vectors and all period registers read zero, the interrupt line is low, and every deadline holds all ones.
- R2: A deadline is reached on a compare cycle when its value is less than or equal to the time input. A value one greater than the time is not reached.
- R3: No deadline is reached, advanced or flagged in any cycle in which the busy input is high. Comparison resumes on the first cycle with busy low.
- R4: A reached one-shot deadline (periodic bit 0) sets its pending bit if its arm bit was 1, and clears its arm bit. It does not fire again until it is re-armed.
- R5: A reached periodic deadline (periodic bit 1) sets its pending bit if armed, keeps its arm bit, and has its period added after zero-extension to 64 bits.
- R6: A periodic deadline that lies far in the past advances by exactly one period per compare cycle until it passes the time input.
- R7: Writing a 1 to a bit of the pending register clears that bit. If a hardware set and a host clear hit the same bit in the same cycle, the bit stays set.
- R8: The interrupt output is high exactly when at least one pending bit is set.
- R9: The register map is: configuration at 0x08 (bits [2:0] deadline count, [7:3] interrupt vector number, [8] separate-interrupts flag), periodic vector at 0x20, arm vector at 0x24, pending vector at 0x28, and the period of deadline n (n from 0) at 0x8C + 0x10·n. Addresses outside this map read zero and ignore writes.
- R10: A host write to the arm vector in the same cycle that a one-shot deadline is reached still leaves that deadline's arm bit cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| time_i | input | 64 | Current value of the time base |
| busy_i | input | 1 | Deadline update in progress; suppresses comparison |
| ld_en_i | input | 1 | Load a new deadline value |
| ld_idx_i | input | 3 | Index of the deadline to load |
| ld_val_i | input | 64 | New deadline value |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 8 | Register write byte address |
| bus_wdata_i | input | 32 | Register write data |
| rd_addr_i | input | 8 | Register read byte address |
| rd_data_o | output | 32 | Register read data (combinational) |
| pend_o | output | 7 | Interrupt pending vector |
| irq_o | output | 1 | Interrupt line |

## Verification
The hardest case to reach from the ports is a periodic deadline that lies several periods behind the time base. Here the bench must count how many single-period steps the engine takes. The count cannot be read back, so the bench writes a pending-clear on every cycle after the first firing. Because a set beats a clear in the same cycle, the pending bit stays high for exactly as many cycles as the deadline keeps firing, and then drops. Getting there means placing the deadline load after the periodic and arm bits are written, so that no step is taken while the deadline is still unarmed.

// File: rtl/dlie_pkg.sv
// Package: shared widths, register offsets and the configuration word
// builder for the deadline compare and interrupt engine.
// Assumes a byte-addressed 8-bit register space with 32-bit data.
package dlie_pkg;
    localparam int TIME_W = 64;
    localparam int PER_W  = 32;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;
    localparam int IDX_W  = 3;

    localparam logic [ADDR_W-1:0] OFF_CFG = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_PE  = 8'h20;
    localparam logic [ADDR_W-1:0] OFF_IE  = 8'h24;
    localparam logic [ADDR_W-1:0] OFF_IP  = 8'h28;

    // Period registers sit at 0x8C + 0x10*n: bit 7 set, low nibble 0xC.
    function automatic logic per_addr_hit(input logic [ADDR_W-1:0] a);
        return a[7] && (a[3:0] == 4'hC);
    endfunction

    // Configuration word: [2:0] count, [7:3] vector, [8] separate lines.
    function automatic logic [DATA_W-1:0] cfg_word(input int cnt, input int vec, input bit sep);
        logic [2:0] c3;
        logic [4:0] v5;
        c3 = cnt[2:0];
        v5 = vec[4:0];
        return {23'd0, sep, v5, c3};
    endfunction
endpackage

// File: rtl/dlie_slot.sv
// One deadline slot: holds the 64-bit deadline and its 32-bit period,
// compares the deadline against the time base and advances it in place
// when periodic. Assumes load requests come from the update logic and
// take priority over periodic advance in the same cycle.
module dlie_slot #(
    parameter int TW = 64,
    parameter int PW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] time_i,
    input  logic          busy_i,
    input  logic          load_i,
    input  logic [TW-1:0] load_val_i,
    input  logic          per_we_i,
    input  logic [PW-1:0] per_wdata_i,
    input  logic          pe_i,
    output logic          hit_o,
    output logic [PW-1:0] per_o
);
    localparam int EXT_W = TW - PW;

    logic [TW-1:0] dl_q;
    logic [PW-1:0] per_q;
    logic [TW-1:0] per_ext;

    assign per_ext = {{EXT_W{1'b0}}, per_q};
    assign per_o   = per_q;

    // Reached test: less-or-equal compare, only on idle cycles.
    assign hit_o = !busy_i && (dl_q <= time_i);

    // Deadline register: load, periodic advance, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dl_q <= '1;
        else if (load_i)
            dl_q <= load_val_i;
        else if (hit_o && pe_i)
            dl_q <= dl_q + per_ext;
    end

    // Period register: host write only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            per_q <= '0;
        else if (per_we_i)
            per_q <= per_wdata_i;
    end

    assert_busy_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && !load_i) |=> $stable(dl_q));

    assert_period_add_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_o && pe_i && !load_i) |=>
            (dl_q == $past(dl_q) + {{EXT_W{1'b0}}, $past(per_q)}));
endmodule

// File: rtl/dlie_flags.sv
// Flag vectors: periodic mode, arm and pending bits for every deadline.
// Sets pending on an armed hit, disarms one-shot hits, and applies host
// writes. Assumes hit pulses already include the busy suppression.
module dlie_flags #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] hit_i,
    input  logic         we_pe_i,
    input  logic         we_ie_i,
    input  logic         we_ip_i,
    input  logic [N-1:0] wdata_i,
    output logic [N-1:0] pe_o,
    output logic [N-1:0] ie_o,
    output logic [N-1:0] ip_o
);
    logic [N-1:0] pe_q, ie_q, ip_q;
    logic [N-1:0] pe_n, ie_n, ip_n;

    // Next-state: host write first, then hardware effects override.
    always_comb begin
        pe_n = we_pe_i ? wdata_i : pe_q;
        ie_n = we_ie_i ? wdata_i : ie_q;
        ie_n = ie_n & ~(hit_i & ~pe_q);
        ip_n = (ip_q & ~(we_ip_i ? wdata_i : '0)) | (hit_i & ie_q);
    end

    // Flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pe_q <= '0;
            ie_q <= '0;
            ip_q <= '0;
        end else begin
            pe_q <= pe_n;
            ie_q <= ie_n;
            ip_q <= ip_n;
        end
    end

    assign pe_o = pe_q;
    assign ie_o = ie_q;
    assign ip_o = ip_q;

    for (genvar i = 0; i < N; i++) begin : g_chk
        assert_disarm_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (hit_i[i] && !pe_q[i]) |=> !ie_q[i]);
        assert_pend_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (hit_i[i] && ie_q[i]) |=> ip_q[i]);
        assert_pend_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ip_q[i]) |-> $past(hit_i[i]));
    end
endmodule

// File: rtl/deadline_irq_engine.sv
// Top: instantiates one slot per deadline plus the flag vectors, decodes
// host writes and serves combinational register reads. Assumes one host
// write per cycle and at most seven deadlines (3-bit count field).
module deadline_irq_engine
    import dlie_pkg::*;
#(
    parameter int N_DL    = 7,
    parameter int IRQ_VEC = 9,
    parameter bit SEP_IRQ = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIME_W-1:0] time_i,
    input  logic              busy_i,
    input  logic              ld_en_i,
    input  logic [IDX_W-1:0]  ld_idx_i,
    input  logic [TIME_W-1:0] ld_val_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic [N_DL-1:0]   pend_o,
    output logic              irq_o
);
    localparam logic [DATA_W-1:0] CFG = cfg_word(N_DL, IRQ_VEC, SEP_IRQ);
    localparam int PAD_W = DATA_W - N_DL;

    logic [N_DL-1:0]  hit;
    logic [N_DL-1:0]  pe, ie, ip;
    logic [PER_W-1:0] per_w [N_DL];
    logic [IDX_W-1:0] wr_idx, rd_idx;
    logic             wr_per, rd_per;

    assign wr_idx = bus_addr_i[6:4];
    assign rd_idx = rd_addr_i[6:4];
    assign wr_per = bus_we_i && per_addr_hit(bus_addr_i);
    assign rd_per = per_addr_hit(rd_addr_i);

    for (genvar i = 0; i < N_DL; i++) begin : g_slot
        dlie_slot #(.TW(TIME_W), .PW(PER_W)) u_slot (
            .clk         (clk),
            .rst_n       (rst_n),
            .time_i      (time_i),
            .busy_i      (busy_i),
            .load_i      (ld_en_i && (ld_idx_i == IDX_W'(i))),
            .load_val_i  (ld_val_i),
            .per_we_i    (wr_per && (wr_idx == IDX_W'(i))),
            .per_wdata_i (bus_wdata_i),
            .pe_i        (pe[i]),
            .hit_o       (hit[i]),
            .per_o       (per_w[i])
        );
    end

    dlie_flags #(.N(N_DL)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit_i   (hit),
        .we_pe_i (bus_we_i && (bus_addr_i == OFF_PE)),
        .we_ie_i (bus_we_i && (bus_addr_i == OFF_IE)),
        .we_ip_i (bus_we_i && (bus_addr_i == OFF_IP)),
        .wdata_i (bus_wdata_i[N_DL-1:0]),
        .pe_o    (pe),
        .ie_o    (ie),
        .ip_o    (ip)
    );

    // Read mux: fixed registers, then period registers, else zero.
    always_comb begin
        rd_data_o = '0;
        case (rd_addr_i)
            OFF_CFG: rd_data_o = CFG;
            OFF_PE:  rd_data_o = {{PAD_W{1'b0}}, pe};
            OFF_IE:  rd_data_o = {{PAD_W{1'b0}}, ie};
            OFF_IP:  rd_data_o = {{PAD_W{1'b0}}, ip};
            default: begin
                for (int k = 0; k < N_DL; k++)
                    if (rd_per && (rd_idx == IDX_W'(k)))
                        rd_data_o = per_w[k];
            end
        endcase
    end

    assign pend_o = ip;
    assign irq_o  = |ip;

    assert_irq_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(|hit));
endmodule

// File: tb/deadline_irq_engine_tb.sv
`timescale 1ns/1ps
module deadline_irq_engine_tb;
    localparam int N = 7;

    typedef struct {
        string       tag;
        bit          is_rd;
        logic [31:0] exp;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [63:0] time_v;
    logic        busy;
    logic        ld_en;
    logic [2:0]  ld_idx;
    logic [63:0] ld_val;
    logic        bus_we;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [7:0]  rd_addr;
    logic [31:0] rd_data;
    logic [N-1:0] pend;
    logic        irq;

    item_t q[$];
    int    n_chk = 0;
    int    n_bad = 0;
    bit    done  = 0;

    always #10 clk = ~clk;

    deadline_irq_engine u_dut (
        .clk(clk), .rst_n(rst_n), .time_i(time_v), .busy_i(busy),
        .ld_en_i(ld_en), .ld_idx_i(ld_idx), .ld_val_i(ld_val),
        .bus_we_i(bus_we), .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data), .pend_o(pend), .irq_o(irq)
    );

    function automatic logic [31:0] pexp(input logic [N-1:0] v);
        return {|v, 24'd0, v};
    endfunction

    function automatic logic [7:0] per_addr(input int n);
        return 8'h8C + 8'(16 * n);
    endfunction

    // Driver helpers: called just after a negedge; expectations refer to
    // the state after the following rising edge.
    task automatic exp_ip(input string tag, input logic [N-1:0] v);
        item_t it;
        it.tag = tag; it.is_rd = 1'b0; it.exp = pexp(v);
        q.push_back(it);
    endtask

    task automatic exp_rd(input string tag, input logic [7:0] a, input logic [31:0] v);
        item_t it;
        rd_addr = a;
        it.tag = tag; it.is_rd = 1'b1; it.exp = v;
        q.push_back(it);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    endtask

    task automatic ld(input int idx, input logic [63:0] v);
        ld_en = 1'b1; ld_idx = 3'(idx); ld_val = v;
    endtask

    task automatic nxt();
        @(negedge clk);
        bus_we = 1'b0;
        ld_en  = 1'b0;
    endtask

    // Monitor: after each rising edge, compare every queued expectation.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            while (q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it  = q.pop_front();
                act = it.is_rd ? rd_data : {irq, 24'd0, pend};
                n_chk++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #(20 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; time_v = 64'd0; busy = 1'b0;
        ld_en = 1'b0; ld_idx = 3'd0; ld_val = 64'd0;
        bus_we = 1'b0; bus_addr = 8'd0; bus_wdata = 32'd0; rd_addr = 8'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        exp_ip("R1 pending after reset", 7'h00);
        exp_rd("R1 periodic vector after reset", 8'h20, 32'h0);
        nxt();
        exp_rd("R1 arm vector after reset", 8'h24, 32'h0);
        nxt();
        exp_rd("R1 period after reset", per_addr(6), 32'h0);
        nxt();

        // R4 / R10 / R7: one-shot deadline in the past
        time_v = 64'd100;
        wr(8'h24, 32'h01); ld(0, 64'd50);
        exp_ip("R4 no fire on load edge", 7'h00);
        nxt();
        wr(8'h24, 32'h01);
        exp_ip("R4 past deadline fires", 7'h01);
        nxt();
        exp_rd("R10 arm cleared despite same-cycle write", 8'h24, 32'h0);
        exp_ip("R8 line held with pending", 7'h01);
        nxt();
        wr(8'h28, 32'h01);
        exp_ip("R7 write-one clears pending", 7'h00);
        nxt();
        exp_ip("R4 disarmed one-shot stays quiet", 7'h00);
        nxt();

        // R2 less-or-equal boundary
        time_v = 64'd199;
        wr(8'h24, 32'h02); ld(1, 64'd200);
        exp_ip("R2 load cycle", 7'h00);
        nxt();
        exp_ip("R2 deadline one above time not reached", 7'h00);
        nxt();
        time_v = 64'd200;
        exp_ip("R2 equal value reached", 7'h02);
        nxt();
        wr(8'h28, 32'h02);
        exp_ip("R7 clear bit1", 7'h00);
        nxt();

        // R3 busy suppression
        busy = 1'b1;
        wr(8'h24, 32'h04); ld(2, 64'd10);
        exp_ip("R3 busy load cycle", 7'h00);
        nxt();
        exp_ip("R3 busy blocks compare", 7'h00);
        nxt();
        exp_ip("R3 busy still blocks", 7'h00);
        nxt();
        busy = 1'b0;
        exp_ip("R3 compare resumes when idle", 7'h04);
        nxt();
        wr(8'h28, 32'h04);
        exp_ip("R7 clear bit2", 7'h00);
        nxt();

        // R5 / R9 periodic deadline with period register
        wr(8'h20, 32'h08); ld(3, 64'd1000); time_v = 64'd900;
        nxt();
        wr(per_addr(3), 32'd100);
        nxt();
        wr(8'h24, 32'h08);
        exp_rd("R9 period readback at 0xBC", per_addr(3), 32'd100);
        nxt();
        time_v = 64'd1000;
        exp_ip("R5 periodic fires", 7'h08);
        nxt();
        wr(8'h28, 32'h08);
        exp_ip("R5 cleared, advanced deadline not reached", 7'h00);
        exp_rd("R5 arm kept on periodic", 8'h24, 32'h08);
        nxt();
        time_v = 64'd1099;
        exp_ip("R5 before next period", 7'h00);
        nxt();
        time_v = 64'd1100;
        exp_ip("R5 fires one period later", 7'h08);
        nxt();
        wr(8'h28, 32'h08);
        exp_ip("R7 clear bit3", 7'h00);
        nxt();

        // R6 / R7 catch-up counted through set-wins-over-clear
        wr(8'h20, 32'h10); time_v = 64'd35;
        nxt();
        wr(per_addr(4), 32'd10);
        nxt();
        wr(8'h24, 32'h10);
        nxt();
        ld(4, 64'd0);
        exp_ip("R6 load cycle", 7'h00);
        nxt();
        exp_ip("R6 first catch-up step", 7'h10);
        nxt();
        for (int k = 0; k < 3; k++) begin
            wr(8'h28, 32'h10);
            exp_ip("R7 set beats same-cycle clear (R6 step)", 7'h10);
            nxt();
        end
        wr(8'h28, 32'h10);
        exp_ip("R6 exactly four steps then past time", 7'h00);
        nxt();

        // R5 zero-extended period
        wr(8'h20, 32'h20); time_v = 64'd5;
        nxt();
        wr(per_addr(5), 32'hFFFF_FFFF);
        nxt();
        wr(8'h24, 32'h20);
        nxt();
        ld(5, 64'd5);
        nxt();
        exp_ip("R5 fire with max period", 7'h20);
        nxt();
        wr(8'h28, 32'h20); time_v = 64'h1_0000_0003;
        exp_ip("R5 zero-extended add not yet reached", 7'h00);
        nxt();
        exp_ip("R5 still below extended deadline", 7'h00);
        nxt();
        time_v = 64'h1_0000_0004;
        exp_ip("R5 reached at deadline plus 2^32-1", 7'h20);
        nxt();

        // R9 map: configuration, vectors, unmapped addresses
        exp_rd("R9 configuration word", 8'h08, 32'h0000_004F);
        nxt();
        exp_rd("R9 periodic vector readback", 8'h20, 32'h20);
        nxt();
        exp_rd("R9 pending readback", 8'h28, 32'h20);
        nxt();
        wr(8'hFC, 32'hDEAD_BEEF);
        exp_rd("R9 unmapped period slot reads zero", 8'hFC, 32'h0);
        nxt();
        wr(8'h2C, 32'h7F);
        exp_ip("R9 unmapped write leaves pending", 7'h20);
        nxt();
        exp_rd("R9 unused address reads zero", 8'h00, 32'h0);
        nxt();
        wr(8'h28, 32'h7F);
        exp_ip("R8 line drops with last pending", 7'h00);
        nxt();
        nxt();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule